// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of address translations. Every entry maps a virtual page number to a physical frame number. Each entry also carries an address-space tag, a valid flag, a write-permission flag and a pin flag. A lookup compares the request against all entries at once. An entry matches only when its page number and its address-space tag are both equal to the request. Because the tag is part of the match, nothing has to be cleared when the active address space changes. The hit flag, the frame and a permission fault are returned one clock after the request.

When a lookup misses, the surrounding logic obtains the translation elsewhere and installs it through the fill port. If the same page and tag are already present, the fill rewrites that entry. Otherwise the fill takes the first free, unpinned slot, searching from a rotating pointer. When no such slot exists, it evicts the first unpinned slot from that pointer. A control port pins or unpins individual slots. Pinned slots are never chosen for replacement. A flush command drops every unpinned translation in one cycle. If every slot is pinned and the fill matches nothing, the fill is refused and a flag reports the refusal.

Top module: `xlat_cache`

## Requirements
- R1: A lookup presented in cycle t returns, after the next rising edge, rsp_valid=1, rsp_hit=1 and the stored frame on rsp_frame when one valid entry has the same page and tag.
- R2: An entry whose tag differs from lk_asid never hits, even when its page number is equal. The same page may be held under two tags at once, each with its own frame.
- R3: After reset every entry is invalid, so every lookup misses. On a miss rsp_frame is 0.
- R4: A fill that is accepted makes a later lookup of that page and tag hit, returning the filled frame.
- R5: A fill whose page and tag match a valid entry overwrites that entry: its frame and write permission change, and no second copy is made.
- R6: A fill that matches nothing takes the first slot that is both invalid and unpinned, searching upward from the rotating pointer with wrap-around. Valid entries are not evicted while such a slot exists.
- R7: When no invalid unpinned slot exists, the fill evicts the first unpinned slot from the pointer. After any fill that is not an overwrite, the pointer moves to the slot after the one used. The pointer is 0 after reset.
- R8: A pinned slot (pin_set=1 written to its index) is never replaced by a fill, whatever the pointer position.
- R9: When every slot is pinned and the fill matches no entry, the fill changes nothing and fill_refused is 1 for the one cycle after the request. A matching fill is still accepted.
- R10: rsp_fault=1 only for a write lookup (lk_write=1) that hits an entry filled with fill_writable=0. Reads, writes to writable entries and misses give rsp_fault=0.
- R11: A flush clears the valid flag of every unpinned entry in one cycle. Pinned entries keep hitting.
- R12: In a cycle after no lookup was presented, rsp_valid, rsp_hit and rsp_fault are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_page | input | PAGE_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Current address-space tag |
| lk_write | input | 1 | 1 for a write access, 0 for a read |
| rsp_valid | output | 1 | Registered: a lookup result is present |
| rsp_hit | output | 1 | Registered: the lookup matched an entry |
| rsp_frame | output | FRAME_W | Registered: frame of the matching entry, 0 on a miss |
| rsp_fault | output | 1 | Registered: write to an entry without write permission |
| fill_valid | input | 1 | Install-translation request |
| fill_page | input | PAGE_W | Page number to install |
| fill_asid | input | ASID_W | Address-space tag to install |
| fill_frame | input | FRAME_W | Frame number to install |
| fill_writable | input | 1 | 1 grants write permission |
| fill_refused | output | 1 | Registered: the previous fill found no slot |
| pin_valid | input | 1 | Write the pin flag of one slot |
| pin_index | input | IDX_W | Slot whose pin flag is written |
| pin_set | input | 1 | 1 pins the slot, 0 unpins it |
| flush | input | 1 | Drop every unpinned translation |

## Verification
The bench fills one page under two tags. A design that ignored the tag would return the wrong frame, or report a fault on the wrong entry. It refills a page that is already present. Creating a duplicate there would either waste a slot or let two entries answer one lookup. It fills past capacity with two slots pinned and checks every survivor against an ordered replacement model. This catches a pointer that does not advance, does not wrap or lands on a pinned slot, and catches an evictor that removes valid entries while free ones remain. It also pins every slot and checks the refusal flag. Finally it issues a flush and checks that pinned mappings still hit while every other mapping misses.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  // How the replacement selector resolved a fill that matched nothing.
  typedef enum logic [1:0] {
    VPICK_NONE  = 2'd0,
    VPICK_FREE  = 2'd1,
    VPICK_EVICT = 2'd2
  } vpick_e;

  // A write that lands on an entry without write permission is a fault.
  function automatic logic write_denied(input logic is_write, input logic writable);
    return is_write && !writable;
  endfunction

endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int ENTRIES = 16,
  parameter int PAGE_W  = 20,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [ENTRIES-1:0]               ent_valid,
  input  logic [ENTRIES-1:0][PAGE_W-1:0]   ent_page,
  input  logic [ENTRIES-1:0][ASID_W-1:0]   ent_asid,
  input  logic [PAGE_W-1:0]                key_page,
  input  logic [ASID_W-1:0]                key_asid,
  output logic                             hit_any,
  output logic [IDX_W-1:0]                 hit_idx
);

  logic [ENTRIES-1:0] hit_vec;

  // Parallel compare: valid flag, page number and tag must all agree.
  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = ent_valid[g] && (ent_page[g] == key_page) && (ent_asid[g] == key_asid);
    end
  endgenerate

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit_any = |hit_vec;

  // Overwrite-on-match in the fill path keeps any key in at most one slot.
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)) else $error("two slots hold the same page and tag"); // R5

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] ent_valid,
  input  logic [ENTRIES-1:0] ent_wired,
  input  logic [IDX_W-1:0]   rr_ptr,
  output vpick_e             pick,
  output logic [IDX_W-1:0]   victim_idx
);

  logic             free_ok, evict_ok;
  logic [IDX_W-1:0] free_idx, evict_idx;

  // Slot reached after 'step' positions from the pointer, with wrap-around.
  function automatic logic [IDX_W-1:0] ring_slot(input logic [IDX_W-1:0] base, input int step);
    return IDX_W'((int'(base) + step) % ENTRIES);
  endfunction

  // Walk from the farthest slot back to the pointer so the nearest one wins.
  always_comb begin
    free_ok   = 1'b0;
    free_idx  = '0;
    evict_ok  = 1'b0;
    evict_idx = '0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      if (!ent_wired[ring_slot(rr_ptr, k)]) begin
        evict_ok  = 1'b1;
        evict_idx = ring_slot(rr_ptr, k);
        if (!ent_valid[ring_slot(rr_ptr, k)]) begin
          free_ok  = 1'b1;
          free_idx = ring_slot(rr_ptr, k);
        end
      end
    end
  end

  always_comb begin
    if (free_ok) begin
      pick       = VPICK_FREE;
      victim_idx = free_idx;
    end else if (evict_ok) begin
      pick       = VPICK_EVICT;
      victim_idx = evict_idx;
    end else begin
      pick       = VPICK_NONE;
      victim_idx = '0;
    end
  end

  AST_VICTIM_UNPINNED: assert property (@(posedge clk) disable iff (!rst_n)
    (pick != VPICK_NONE) |-> !ent_wired[victim_idx]) else $error("pinned slot chosen"); // R8
  AST_FREE_BEFORE_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
    (pick == VPICK_EVICT) |-> ((~ent_valid & ~ent_wired) == '0)) else $error("evicting while free slot exists"); // R6
  AST_NONE_ONLY_ALL_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
    (pick == VPICK_NONE) |-> (&ent_wired)) else $error("no victim despite unpinned slot"); // R9

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PAGE_W  = 20,
  parameter int ASID_W  = 8,
  parameter int FRAME_W = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic [PAGE_W-1:0]  lk_page,
  input  logic [ASID_W-1:0]  lk_asid,
  input  logic               lk_write,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [FRAME_W-1:0] rsp_frame,
  output logic               rsp_fault,
  input  logic               fill_valid,
  input  logic [PAGE_W-1:0]  fill_page,
  input  logic [ASID_W-1:0]  fill_asid,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic               fill_writable,
  output logic               fill_refused,
  input  logic               pin_valid,
  input  logic [IDX_W-1:0]   pin_index,
  input  logic               pin_set,
  input  logic               flush
);

  // Entry state
  logic [ENTRIES-1:0]              v_q, w_q, wr_q;
  logic [ENTRIES-1:0][PAGE_W-1:0]  pg_q;
  logic [ENTRIES-1:0][ASID_W-1:0]  as_q;
  logic [ENTRIES-1:0][FRAME_W-1:0] fr_q;
  logic [IDX_W-1:0]                rr_q;

  // Named internal events
  logic             lk_any, fl_any;
  logic [IDX_W-1:0] lk_idx, fl_idx, victim_idx, fill_tgt;
  vpick_e           pick;
  logic             fill_accept, fill_refuse, fill_replace;

  xlat_match #(.ENTRIES(ENTRIES), .PAGE_W(PAGE_W), .ASID_W(ASID_W)) u_lk_match (
    .clk(clk), .rst_n(rst_n), .ent_valid(v_q), .ent_page(pg_q), .ent_asid(as_q),
    .key_page(lk_page), .key_asid(lk_asid), .hit_any(lk_any), .hit_idx(lk_idx));

  xlat_match #(.ENTRIES(ENTRIES), .PAGE_W(PAGE_W), .ASID_W(ASID_W)) u_fl_match (
    .clk(clk), .rst_n(rst_n), .ent_valid(v_q), .ent_page(pg_q), .ent_asid(as_q),
    .key_page(fill_page), .key_asid(fill_asid), .hit_any(fl_any), .hit_idx(fl_idx));

  xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .ent_valid(v_q), .ent_wired(w_q), .rr_ptr(rr_q),
    .pick(pick), .victim_idx(victim_idx));

  // Fill target: an existing copy first, otherwise the replacement choice.
  assign fill_replace = !fl_any && (pick != VPICK_NONE);
  assign fill_accept  = fl_any || fill_replace;
  assign fill_refuse  = !fill_accept;
  assign fill_tgt     = fl_any ? fl_idx : victim_idx;

  function automatic logic [IDX_W-1:0] next_slot(input logic [IDX_W-1:0] cur);
    return IDX_W'((int'(cur) + 1) % ENTRIES);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q          <= '0;
      w_q          <= '0;
      wr_q         <= '0;
      pg_q         <= '0;
      as_q         <= '0;
      fr_q         <= '0;
      rr_q         <= '0;
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_frame    <= '0;
      rsp_fault    <= 1'b0;
      fill_refused <= 1'b0;
    end else begin
      rsp_valid    <= lk_valid;
      rsp_hit      <= lk_valid && lk_any;
      rsp_frame    <= (lk_valid && lk_any) ? fr_q[lk_idx] : '0;
      rsp_fault    <= lk_valid && lk_any && write_denied(lk_write, wr_q[lk_idx]);
      fill_refused <= fill_valid && fill_refuse;

      if (flush) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (!w_q[i]) v_q[i] <= 1'b0;
        end
      end
      if (pin_valid) w_q[pin_index] <= pin_set;
      if (fill_valid && fill_accept) begin
        v_q[fill_tgt]  <= 1'b1;
        pg_q[fill_tgt] <= fill_page;
        as_q[fill_tgt] <= fill_asid;
        fr_q[fill_tgt] <= fill_frame;
        wr_q[fill_tgt] <= fill_writable;
        if (fill_replace) rr_q <= next_slot(fill_tgt);
      end
    end
  end

  AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_hit) else $error("fault without hit"); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_hit && !rsp_fault)) else $error("result flags without lookup"); // R12
  AST_FLUSH_SPARES_WIRED: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !fill_valid) |=> ((v_q & ~$past(w_q)) == '0)) else $error("unpinned entry survived flush"); // R11
  AST_REFUSE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_refuse && !flush) |=> (v_q == $past(v_q) && fill_refused)) else $error("refused fill changed state"); // R9
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_accept) |=> v_q[$past(fill_tgt)]) else $error("accepted fill not valid"); // R4

endmodule

// File: tb/xlat_cache_test.sv
module xlat_cache_test;

  localparam int N  = 16;
  localparam int PW = 20;
  localparam int AW = 8;
  localparam int FW = 16;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0, lk_write = 1'b0;
  logic [PW-1:0] lk_page = '0;
  logic [AW-1:0] lk_asid = '0;
  logic rsp_valid, rsp_hit, rsp_fault, fill_refused;
  logic [FW-1:0] rsp_frame;
  logic fill_valid = 1'b0, fill_writable = 1'b0;
  logic [PW-1:0] fill_page = '0;
  logic [AW-1:0] fill_asid = '0;
  logic [FW-1:0] fill_frame = '0;
  logic pin_valid = 1'b0, pin_set = 1'b0, flush = 1'b0;
  logic [IW-1:0] pin_index = '0;

  always #5 clk = ~clk;

  xlat_cache uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_page(lk_page), .lk_asid(lk_asid), .lk_write(lk_write),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_frame(rsp_frame), .rsp_fault(rsp_fault),
    .fill_valid(fill_valid), .fill_page(fill_page), .fill_asid(fill_asid),
    .fill_frame(fill_frame), .fill_writable(fill_writable), .fill_refused(fill_refused),
    .pin_valid(pin_valid), .pin_index(pin_index), .pin_set(pin_set), .flush(flush));

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // Reference model of the requirements
  bit            m_v[N], m_w[N], m_wr[N];
  logic [PW-1:0] m_pg[N];
  logic [AW-1:0] m_as[N];
  logic [FW-1:0] m_fr[N];
  int            m_ptr = 0;

  // Scoreboard queues
  bit            q_hit[$];
  logic [FW-1:0] q_frame[$];
  bit            q_fault[$];
  string         q_tag[$];

  task automatic check_eq(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic drive_idle();
    lk_valid = 1'b0; lk_write = 1'b0;
    fill_valid = 1'b0; pin_valid = 1'b0; flush = 1'b0;
  endtask

  task automatic idle(int cycles = 1);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      drive_idle();
    end
  endtask

  // Driver: present a lookup and push the expected result.
  task automatic lookup(logic [PW-1:0] page, logic [AW-1:0] asid, bit wr, string tag);
    bit h; logic [FW-1:0] f; bit flt;
    @(negedge clk);
    drive_idle();
    h = 0; f = '0; flt = 0;
    for (int i = 0; i < N; i++) begin
      if (m_v[i] && m_pg[i] == page && m_as[i] == asid) begin
        h = 1; f = m_fr[i]; flt = wr && !m_wr[i];
      end
    end
    q_hit.push_back(h); q_frame.push_back(f); q_fault.push_back(flt); q_tag.push_back(tag);
    lk_valid = 1'b1; lk_page = page; lk_asid = asid; lk_write = wr;
  endtask

  // Monitor: compare each result against the oldest expectation.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_hit.size() == 0) begin
        check_eq("R12", "unexpected result", 1, 0);
      end else begin
        string t;
        t = q_tag.pop_front();
        check_eq(t, "hit", rsp_hit, q_hit.pop_front());
        check_eq(t, "frame", rsp_frame, q_frame.pop_front());
        check_eq(t, "fault", rsp_fault, q_fault.pop_front());
      end
    end
  end

  task automatic fill(logic [PW-1:0] page, logic [AW-1:0] asid, logic [FW-1:0] frame,
                      bit wr, string tag);
    int tgt; bit refuse; bit replaced;
    @(negedge clk);
    drive_idle();
    tgt = -1; replaced = 0;
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_pg[i] == page && m_as[i] == asid) tgt = i;
    if (tgt < 0) begin
      for (int k = 0; k < N; k++) begin
        if (tgt < 0 && !m_w[(m_ptr + k) % N] && !m_v[(m_ptr + k) % N]) tgt = (m_ptr + k) % N;
      end
      for (int k = 0; k < N; k++) begin
        if (tgt < 0 && !m_w[(m_ptr + k) % N]) tgt = (m_ptr + k) % N;
      end
      replaced = (tgt >= 0);
    end
    refuse = (tgt < 0);
    if (!refuse) begin
      m_v[tgt] = 1; m_pg[tgt] = page; m_as[tgt] = asid; m_fr[tgt] = frame; m_wr[tgt] = wr;
      if (replaced) m_ptr = (tgt + 1) % N;
    end
    fill_valid = 1'b1; fill_page = page; fill_asid = asid; fill_frame = frame; fill_writable = wr;
    @(negedge clk);
    drive_idle();
    check_eq(tag, "fill_refused", fill_refused, refuse);
  endtask

  task automatic pin(int idx, bit set);
    @(negedge clk);
    drive_idle();
    m_w[idx] = set;
    pin_valid = 1'b1; pin_index = IW'(idx); pin_set = set;
  endtask

  task automatic do_flush();
    @(negedge clk);
    drive_idle();
    for (int i = 0; i < N; i++) if (!m_w[i]) m_v[i] = 0;
    flush = 1'b1;
  endtask

  // Watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_w[i] = 0; m_wr[i] = 0; m_pg[i] = '0; m_as[i] = '0; m_fr[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R12", "rsp_valid idle", rsp_valid, 0);
    check_eq("R12", "rsp_hit idle", rsp_hit, 0);
    check_eq("R9", "fill_refused after reset", fill_refused, 0);

    // R3: empty after reset
    lookup(20'h5, 8'h1, 0, "R3");
    idle();

    // R4 / R1 / R2 / R10
    fill(20'h10, 8'h1, 16'h21, 0, "R4");
    fill(20'h11, 8'h1, 16'h22, 1, "R4");
    lookup(20'h10, 8'h1, 0, "R1");
    lookup(20'h10, 8'h2, 0, "R2");
    lookup(20'h10, 8'h1, 1, "R10");
    lookup(20'h11, 8'h1, 1, "R10");
    lookup(20'h55, 8'h1, 1, "R10");
    idle(2);

    // R5: overwrite in place
    fill(20'h10, 8'h1, 16'h99, 1, "R5");
    lookup(20'h10, 8'h1, 1, "R5");
    idle();

    // R2: same page, another tag
    fill(20'h10, 8'h2, 16'h77, 0, "R2");
    lookup(20'h10, 8'h2, 0, "R2");
    lookup(20'h10, 8'h1, 0, "R2");
    idle();

    // R6: fill remaining free slots, nothing evicted
    for (int i = 0; i < 13; i++) fill(20'h100 + PW'(i), 8'h3, 16'h300 + FW'(i), 1, "R6");
    lookup(20'h10, 8'h1, 0, "R6");
    lookup(20'h11, 8'h1, 0, "R6");
    lookup(20'h10, 8'h2, 0, "R6");
    for (int i = 0; i < 13; i++) lookup(20'h100 + PW'(i), 8'h3, 0, "R6");
    idle(2);

    // R7 / R8: pin slots 0 and 1, overflow by many fills
    pin(0, 1);
    pin(1, 1);
    for (int i = 0; i < 20; i++) fill(20'h200 + PW'(i), 8'h4, 16'h400 + FW'(i), 0, "R7");
    lookup(20'h10, 8'h1, 0, "R8");
    lookup(20'h11, 8'h1, 0, "R8");
    for (int i = 0; i < 20; i++) lookup(20'h200 + PW'(i), 8'h4, 0, "R7");
    for (int i = 0; i < 13; i += 4) lookup(20'h100 + PW'(i), 8'h3, 0, "R7");
    idle(2);

    // R9: all pinned
    for (int i = 0; i < N; i++) pin(i, 1);
    fill(20'h400, 8'h5, 16'h5A5, 1, "R9");
    lookup(20'h400, 8'h5, 0, "R9");
    fill(20'h11, 8'h1, 16'h55, 0, "R9");
    lookup(20'h11, 8'h1, 1, "R9");
    idle();

    // R11: flush keeps only pinned slots 0 and 1
    for (int i = 2; i < N; i++) pin(i, 0);
    do_flush();
    lookup(20'h10, 8'h1, 0, "R11");
    lookup(20'h11, 8'h1, 0, "R11");
    for (int i = 0; i < 20; i += 3) lookup(20'h200 + PW'(i), 8'h4, 0, "R11");
    lookup(20'h10, 8'h2, 0, "R11");
    idle();
    fill(20'h600, 8'h6, 16'h66, 1, "R6");
    lookup(20'h600, 8'h6, 1, "R6");
    idle(4);

    check_eq("R12", "scoreboard drained", q_hit.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule